// File: doc/BRIEF.md
# PPS pulse generator

This block turns a free-running nanosecond time value into a programmable square wave on one output pin. It holds a 64-bit fixed-point threshold (whole nanoseconds in the upper half, fraction in the lower half). It compares the running time against that threshold every cycle. When the time reaches the threshold, the internal level flips. The threshold then moves forward by one of two programmable increments: the high-phase increment if the new level is high, the low-phase increment if it is low. The high and low durations are therefore set independently, and a symmetric wave uses half the period in each.

The time input wraps at a parameterised rollover (one second by default). The threshold is stored modulo that rollover, together with a small signed count of rollovers still to pass. This lets a single phase last several seconds, up to 4 s high plus 4 s low at the default settings. A control word carries an enable bit and a polarity-invert bit. Disabling forces the wave to its inactive level. Inversion is applied after the toggle logic, so it never disturbs the phase sequence.

Top module: `pps_gen`

## Requirements
- R1: After reset the internal level is low. With the control word at zero, pps_o is 0, and no toggle happens until enable is set.
- R2: Enable is bit 30 and invert is bit 31 of cfg_i. All other cfg_i bits have no effect on pps_o.
- R3: While enabled, the level toggles at the clock edge where the time ({time_ns_i, time_frac_i}, nanoseconds in bits 63:32, fraction in bits 31:0) is greater than or equal to the threshold. The compare uses the full 64-bit value, fraction included.
- R4: After a toggle, the threshold advances by hi_incr_i if the new level is high, or by lo_incr_i if it is low. Each increment carries nanoseconds in bits 63:32 and a fraction in bits 31:0.
- R5: A threshold that passes the rollover is reduced modulo ROLL_NS and fires only after the matching number of time rollovers. Phases longer than one rollover period (up to MAX_WRAP-1 periods) are timed exactly.
- R6: A threshold that the time steps over across a rollover, without ever being met in range, fires at the edge where the rollover is seen.
- R7: While disabled, pps_o equals the invert bit and the level is cleared. The threshold does not advance, and it is re-anchored to the current rollover period.
- R8: A threshold load (thr_wr_i) takes priority over a toggle at the same edge. It places the loaded value in the current rollover period and leaves the level unchanged.
- R9: pps_o is the enabled level XOR invert. Flipping invert while running flips pps_o at once and leaves the toggle times unchanged.
- R10: A threshold that lies behind the time produces toggles on consecutive edges until it has advanced past the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| time_ns_i | input | 32 | Running time, whole nanoseconds, wraps at ROLL_NS |
| time_frac_i | input | 32 | Running time, fractional nanoseconds |
| cfg_i | input | 32 | Control word: bit 30 enable, bit 31 invert |
| thr_wr_i | input | 1 | Load strobe for the threshold |
| thr_ns_i | input | 32 | Threshold load value, nanoseconds (below ROLL_NS) |
| thr_frac_i | input | 32 | Threshold load value, fraction |
| hi_incr_i | input | 64 | High-phase increment, ns in 63:32, fraction in 31:0 |
| lo_incr_i | input | 64 | Low-phase increment, ns in 63:32, fraction in 31:0 |
| pps_o | output | 1 | Square-wave output |

## Verification
The wave is driven in several configurations:
- Equal increments check the basic alternation.
- Unequal increments with fractional parts show whether the high and low values are swapped or the fraction is dropped.
- Multi-period phases check the rollover counting.
- A coarse time step skips thresholds across the rollover.

Further runs load a zero threshold mid-period to force catch-up toggling, flip invert and enable while running, and set every unused control bit to show that it has no effect. An unwrapped absolute-time model tracks each of these cases and separates wrap-count errors from plain compare errors.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int unsigned NS_W   = 32;
  localparam int unsigned FRAC_W = 32;
  localparam int unsigned TS_W   = NS_W + FRAC_W;
  localparam int unsigned CFG_W  = 32;

  typedef logic [TS_W-1:0] ts_t;
endpackage

// File: rtl/pps_wrap_detect.sv
module pps_wrap_detect
  import pps_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NS_W-1:0] time_ns_i,
  output logic            roll_o
);
  logic [NS_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= time_ns_i;
  end

  // time went backwards: counter passed its rollover
  assign roll_o = time_ns_i < prev_q;
endmodule

// File: rtl/pps_thresh_adv.sv
module pps_thresh_adv
  import pps_pkg::*;
#(
  parameter int unsigned ROLL_NS  = 1000000000,
  parameter int unsigned MAX_WRAP = 5,
  localparam int unsigned KW      = $clog2(MAX_WRAP + 1)
) (
  input  logic [NS_W-1:0]   thr_ns_i,
  input  logic [FRAC_W-1:0] thr_frac_i,
  input  ts_t               incr_i,
  output logic [NS_W-1:0]   res_ns_o,
  output logic [FRAC_W-1:0] res_frac_o,
  output logic [KW-1:0]     wraps_o
);
  logic [TS_W:0]       sum;
  logic [63:0]         sum_ns64;
  logic [MAX_WRAP-1:0] ge;
  logic [63:0]         kroll;

  assign sum      = {1'b0, thr_ns_i, thr_frac_i} + {1'b0, incr_i};
  assign sum_ns64 = 64'(sum[TS_W:FRAC_W]);

  // thermometer of rollover multiples crossed
  for (genvar j = 1; j <= MAX_WRAP; j++) begin : g_mult
    assign ge[j-1] = sum_ns64 >= 64'(j) * 64'(ROLL_NS);
  end

  always_comb begin
    wraps_o = '0;
    for (int i = 0; i < MAX_WRAP; i++) wraps_o = wraps_o + KW'(ge[i]);
  end

  assign kroll      = 64'(wraps_o) * 64'(ROLL_NS);
  assign res_ns_o   = NS_W'(sum_ns64 - kroll);
  assign res_frac_o = sum[FRAC_W-1:0];

  always_comb begin
    if (thr_ns_i < NS_W'(ROLL_NS) && sum_ns64 < 64'(MAX_WRAP + 1) * 64'(ROLL_NS))
      a_res_range_r5: assert (res_ns_o < NS_W'(ROLL_NS));
  end
endmodule

// File: rtl/pps_phase_ctrl.sv
module pps_phase_ctrl
  import pps_pkg::*;
#(
  parameter int unsigned ROLL_NS  = 1000000000,
  parameter int unsigned MAX_WRAP = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              roll_i,
  input  logic [NS_W-1:0]   time_ns_i,
  input  logic [FRAC_W-1:0] time_frac_i,
  input  logic              thr_wr_i,
  input  logic [NS_W-1:0]   thr_ns_i,
  input  logic [FRAC_W-1:0] thr_frac_i,
  input  ts_t               hi_incr_i,
  input  ts_t               lo_incr_i,
  output logic              level_o
);
  localparam int unsigned KW = $clog2(MAX_WRAP + 1);
  localparam int unsigned WW = KW + 2;
  localparam logic signed [WW-1:0] W_NEG1 = '1;
  localparam logic signed [WW-1:0] W_MAX  = WW'(MAX_WRAP);

  logic [NS_W-1:0]         thr_ns_q;
  logic [FRAC_W-1:0]       thr_frac_q;
  logic signed [WW-1:0]    wraps_q, eff, adv_wraps;
  logic                    level_q, time_ge, hit, toggle;
  ts_t                     incr;
  logic [NS_W-1:0]         res_ns;
  logic [FRAC_W-1:0]       res_frac;
  logic [KW-1:0]           k;

  // rollovers still to pass, after this cycle's rollover
  assign eff     = wraps_q - $signed({{(WW-1){1'b0}}, roll_i});
  assign time_ge = {time_ns_i, time_frac_i} >= {thr_ns_q, thr_frac_q};
  assign hit     = en_i && (eff[WW-1] || (eff == '0 && time_ge));
  assign toggle  = hit && !thr_wr_i;
  assign incr    = level_q ? lo_incr_i : hi_incr_i;

  pps_thresh_adv #(
    .ROLL_NS  (ROLL_NS),
    .MAX_WRAP (MAX_WRAP)
  ) u_adv (
    .thr_ns_i   (thr_ns_q),
    .thr_frac_i (thr_frac_q),
    .incr_i     (incr),
    .res_ns_o   (res_ns),
    .res_frac_o (res_frac),
    .wraps_o    (k)
  );

  always_comb begin
    adv_wraps = $signed({2'b00, k}) + eff;
    if (adv_wraps < W_NEG1) adv_wraps = W_NEG1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_ns_q   <= '0;
      thr_frac_q <= '0;
      wraps_q    <= '0;
      level_q    <= 1'b0;
    end else begin
      if (thr_wr_i) begin
        thr_ns_q   <= thr_ns_i;
        thr_frac_q <= thr_frac_i;
        wraps_q    <= '0;
      end else if (!en_i) begin
        wraps_q    <= '0;
      end else if (hit) begin
        thr_ns_q   <= res_ns;
        thr_frac_q <= res_frac;
        wraps_q    <= adv_wraps;
      end else begin
        wraps_q    <= eff;
      end

      if (!en_i)       level_q <= 1'b0;
      else if (toggle) level_q <= ~level_q;
    end
  end

  assign level_o = level_q;

  p_wraps_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wraps_q >= W_NEG1 && wraps_q <= W_MAX);

  p_disabled_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !level_q);

  p_load_keeps_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && thr_wr_i) |=> $stable(level_q));

  p_pending_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !thr_wr_i && !roll_i && !hit) |=> $stable(wraps_q) && $stable(thr_ns_q));

  p_future_no_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !roll_i && wraps_q > 0) |=> $stable(level_q));
endmodule

// File: rtl/pps_gen.sv
module pps_gen
  import pps_pkg::*;
#(
  parameter int unsigned ROLL_NS  = 1000000000,
  parameter int unsigned MAX_WRAP = 5,
  parameter int unsigned EN_BIT   = 30,
  parameter int unsigned INV_BIT  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NS_W-1:0]   time_ns_i,
  input  logic [FRAC_W-1:0] time_frac_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              thr_wr_i,
  input  logic [NS_W-1:0]   thr_ns_i,
  input  logic [FRAC_W-1:0] thr_frac_i,
  input  logic [TS_W-1:0]   hi_incr_i,
  input  logic [TS_W-1:0]   lo_incr_i,
  output logic              pps_o
);
  logic en, inv, roll, level;

  assign en  = cfg_i[EN_BIT];
  assign inv = cfg_i[INV_BIT];

  pps_wrap_detect u_wrap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .time_ns_i (time_ns_i),
    .roll_o    (roll)
  );

  pps_phase_ctrl #(
    .ROLL_NS  (ROLL_NS),
    .MAX_WRAP (MAX_WRAP)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .roll_i      (roll),
    .time_ns_i   (time_ns_i),
    .time_frac_i (time_frac_i),
    .thr_wr_i    (thr_wr_i),
    .thr_ns_i    (thr_ns_i),
    .thr_frac_i  (thr_frac_i),
    .hi_incr_i   (hi_incr_i),
    .lo_incr_i   (lo_incr_i),
    .level_o     (level)
  );

  // polarity after toggle logic
  assign pps_o = (en & level) ^ inv;
endmodule

// File: tb/pps_gen_tb_top.sv
module pps_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROLL       = 1000;
  localparam int MAXW       = 8;
  localparam longint RS     = longint'(ROLL) <<< 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] time_ns = '0, time_frac = '0, cfg = '0, thr_ns = '0, thr_frac = '0;
  logic        thr_wr = 1'b0;
  logic [63:0] hi_incr = '0, lo_incr = '0;
  logic        pps;

  always #(CLK_PERIOD/2) clk = ~clk;

  pps_gen #(.ROLL_NS(ROLL), .MAX_WRAP(MAXW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .time_ns_i(time_ns), .time_frac_i(time_frac),
    .cfg_i(cfg), .thr_wr_i(thr_wr), .thr_ns_i(thr_ns), .thr_frac_i(thr_frac),
    .hi_incr_i(hi_incr), .lo_incr_i(lo_incr), .pps_o(pps)
  );

  longint abs_t = 0, abs_thr = 0, step = (longint'(7) <<< 32) | (longint'(1) <<< 30);
  bit     m_level = 1'b0;
  int     n_run = 0, n_fail = 0;
  string  tag = "R1";

  task automatic check_out();
    bit en, inv, exp;
    en  = cfg[30];
    inv = cfg[31];
    exp = (en & m_level) ^ inv;
    n_run++;
    if (pps !== exp) begin
      n_fail++;
      $display("FAIL %s: t=%0t pps_o=%0b expected %0b", tag, $time, pps, exp);
    end
  endtask

  // apply inputs for next edge, update model, wait, compare
  task automatic cyc();
    bit en;
    abs_t     += step;
    time_ns   = 32'((abs_t >>> 32) % ROLL);
    time_frac = abs_t[31:0];
    en = cfg[30];
    if (thr_wr)
      abs_thr = (abs_t / RS) * RS + longint'({thr_ns, thr_frac});
    else if (!en)
      abs_thr = (abs_t / RS) * RS + (abs_thr % RS);
    else if (abs_t >= abs_thr) begin
      m_level = ~m_level;
      abs_thr += m_level ? longint'(hi_incr) : longint'(lo_incr);
    end
    if (!en) m_level = 1'b0;
    @(negedge clk);
    check_out();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic load(logic [31:0] ns, logic [31:0] fr);
    thr_ns = ns; thr_frac = fr; thr_wr = 1'b1;
    cyc();
    thr_wr = 1'b0;
  endtask

  function automatic logic [63:0] mk(int ns, logic [31:0] fr);
    return {32'(ns), fr};
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    tag = "R1"; check_out();
    rst_ni = 1'b1;
    run(20);                                   // R1: idle after reset

    tag = "R2"; cfg = 32'h3FFF_FFFF; run(30);  // R2: junk bits only
    tag = "R7"; cfg = 32'h8000_0000; run(30);  // R7: disabled shows invert

    tag = "R3"; cfg = 32'h0;
    hi_incr = mk(250, 0); lo_incr = mk(250, 0);
    load(0, 0);
    cfg = 32'h4000_0000; run(800);             // R3/R4 symmetric

    tag = "R10"; hi_incr = mk(100, 0); lo_incr = mk(100, 0);
    load(0, 0);                                // R8/R10: load behind time
    run(300);

    tag = "R4"; hi_incr = mk(120, 32'h8000_0000); lo_incr = mk(333, 32'h1234_5678);
    run(800);

    tag = "R5"; hi_incr = mk(3500, 32'h100); lo_incr = mk(2200, 0);
    run(3000);

    tag = "R6"; step = (longint'(37) <<< 32) | (longint'(1) <<< 31);
    hi_incr = mk(500, 0); lo_incr = mk(500, 0);
    load(999, 32'hF000_0000);
    run(400);
    load(990, 0);
    run(200);

    tag = "R9"; step = (longint'(7) <<< 32) | (longint'(1) <<< 30);
    cfg = 32'hC000_0000; run(200);
    cfg = 32'h4000_0000; run(100);

    tag = "R7"; cfg = 32'h8000_0000; run(150);
    cfg = 32'h4000_0000; run(300);

    tag = "R8"; hi_incr = mk(80, 32'h4000_0000); lo_incr = mk(170, 0);
    load(500, 0); run(50); load(200, 0); run(300);

    tag = "R2"; cfg = 32'h7FFF_FFFF; run(300);
    cfg = 32'hBFFF_FFFF; run(100);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule